// File: doc/BRIEF.md
# Multiply-Accumulate Register Peripheral

A word-wide arithmetic helper that sits on a simple synchronous register bus. Software writes a first operand into one of four operand slots, and the slot it picks decides the operation: unsigned multiply, signed multiply, unsigned accumulate or signed accumulate. Writing the second operand fires the selected operation in the same clock edge. The 32-bit result is then read back as two halves, together with an extension word whose meaning follows the current mode.

The accumulate modes add each new product into a running 32-bit accumulator. A plain multiply replaces the result and clears that accumulator. Software can seed the accumulator by writing the low result slot; the value is widened with zeros or with its sign bit, depending on whether the current mode is unsigned or signed. Only aligned 16-bit accesses inside the sixteen-byte window do anything.

Top module: `mac_periph`

## Requirements
- R1: A write to byte offset 0x130, 0x132, 0x134 or 0x136 stores the first operand and selects unsigned multiply, signed multiply, unsigned accumulate or signed accumulate respectively; a read of any of these four offsets returns the stored first operand.
- R2: A write to offset 0x138 stores the second operand and performs the operation chosen by the most recent first-operand write, in the same clock edge; a read of 0x138 returns the stored second operand.
- R3: In the two plain multiply modes the 32-bit product replaces the result and the accumulator becomes zero, so a following accumulate starts from zero.
- R4: In the two accumulate modes the product is added to the accumulator modulo 2^32 and the result shows the new sum.
- R5: In signed modes both 16-bit operands are treated as two's complement before multiplying; in unsigned modes they are treated as plain binary.
- R6: The extension word at 0x13E depends on the currently selected mode: 0x0000 in unsigned multiply; 0xFFFF in either signed mode when bit 31 of the result is set and 0x0000 otherwise; in unsigned accumulate 0x0001 when the latest unsigned accumulate carried out of bit 31 and 0x0000 otherwise (the carry is cleared by any other operation and by a preload).
- R7: A write to 0x13A loads both result and accumulator with the written word, zero-extended in unsigned modes and sign-extended in signed modes.
- R8: Reads of 0x13A and 0x13C return bits 15:0 and 31:16 of the result; read data appears on the output at the clock edge that samples the read strobe and holds until the next read.
- R9: Writes to odd offsets or to addresses outside 0x130 to 0x13F change nothing, and reads of them return 0x0000.
- R10: After reset every register, the mode (unsigned multiply) and the read data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (16) | Byte address of the access |
| wdata | input | DATA_W (16) | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W (16) | Registered read data |

## Verification
Every operation completes in the edge that samples the second-operand or preload write, so any read strobed in the next cycle already sees the new result; the read data itself arrives one edge after its strobe. The bench drives each access on a falling edge, lets exactly one rising edge pass, and samples read data on the following falling edge, keeping writes and reads in separate cycles. A sweep over corner operand pairs in all four modes compares low, high and extension words against a 64-bit arithmetic model, with the accumulator carried across pairs so wrap and carry cases arise naturally.

// File: rtl/mac_periph.sv
module mac_periph #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter int unsigned BASE_ADDR = 'h130
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata
);

  localparam int RES_W  = 2 * DATA_W;
  localparam int WIN_B  = 16;
  localparam int SLOT_W = 3;

  localparam logic [SLOT_W-1:0] SLOT_OP2 = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_LO  = 3'd5;
  localparam logic [SLOT_W-1:0] SLOT_HI  = 3'd6;
  localparam logic [SLOT_W-1:0] SLOT_EXT = 3'd7;

  localparam logic [1:0] M_UMUL = 2'd0;
  localparam logic [1:0] M_SMUL = 2'd1;
  localparam logic [1:0] M_UMAC = 2'd2;
  localparam logic [1:0] M_SMAC = 2'd3;

  logic [DATA_W-1:0] op1, op2;
  logic [1:0]        mode;
  logic [RES_W-1:0]  res, acc;
  logic              carry;

  logic [ADDR_W-1:0] off;
  logic              hit;
  logic [SLOT_W-1:0] slot;
  assign off  = addr - ADDR_W'(BASE_ADDR);
  assign hit  = (off < ADDR_W'(WIN_B)) && !off[0];
  assign slot = off[SLOT_W:1];

  logic wr_op1, wr_op2, wr_lo;
  assign wr_op1 = wr_en && hit && !slot[SLOT_W-1];
  assign wr_op2 = wr_en && hit && (slot == SLOT_OP2);
  assign wr_lo  = wr_en && hit && (slot == SLOT_LO);

  logic sgn, accm;
  assign sgn  = mode[0];
  assign accm = mode[1];

  logic [RES_W-1:0] a_x, b_x, prod, ld_val;
  logic [RES_W:0]   sum;
  assign a_x    = {{DATA_W{sgn & op1[DATA_W-1]}}, op1};
  assign b_x    = {{DATA_W{sgn & wdata[DATA_W-1]}}, wdata};
  assign prod   = a_x * b_x;
  assign sum    = {1'b0, acc} + {1'b0, prod};
  assign ld_val = {{DATA_W{sgn & wdata[DATA_W-1]}}, wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1   <= '0;
      op2   <= '0;
      mode  <= M_UMUL;
      res   <= '0;
      acc   <= '0;
      carry <= 1'b0;
    end else if (wr_op1) begin
      op1  <= wdata;
      mode <= slot[1:0];
    end else if (wr_op2) begin
      op2 <= wdata;
      if (accm) begin
        acc   <= sum[RES_W-1:0];
        res   <= sum[RES_W-1:0];
        carry <= !sgn && sum[RES_W];
      end else begin
        acc   <= '0;
        res   <= prod;
        carry <= 1'b0;
      end
    end else if (wr_lo) begin
      acc   <= ld_val;
      res   <= ld_val;
      carry <= 1'b0;
    end
  end

  logic [DATA_W-1:0] ext;
  always_comb begin
    case (mode)
      M_UMUL:  ext = '0;
      M_UMAC:  ext = {{(DATA_W-1){1'b0}}, carry};
      default: ext = {DATA_W{res[RES_W-1]}};
    endcase
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (slot)
        SLOT_OP2: rd_mux = op2;
        SLOT_LO:  rd_mux = res[DATA_W-1:0];
        SLOT_HI:  rd_mux = res[RES_W-1:DATA_W];
        SLOT_EXT: rd_mux = ext;
        default:  rd_mux = op1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_MUL_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op2 && (mode == M_UMUL || mode == M_SMUL)) |=> (acc == '0)); // R3
  AST_MAC_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op2 && (mode == M_UMAC || mode == M_SMAC)) |=> (res == $past(acc) + $past(prod) && acc == res)); // R4
  AST_PRELOAD_ZX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !mode[0]) |=> (res == {{DATA_W{1'b0}}, $past(wdata)})); // R7
  AST_PRELOAD_SX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && mode[0]) |=> (res[RES_W-1:DATA_W] == {DATA_W{$past(wdata[DATA_W-1])}})); // R7
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> ($stable(res) && $stable(acc) && $stable(op1) && $stable(op2) && $stable(mode))); // R9
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rdata == '0)); // R9
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R8

endmodule

// File: tb/sim_mac_periph.sv
`timescale 1ns/100ps
module sim_mac_periph;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam int B = 'h130;

  logic [1:0]  m_mode = 0;
  logic [15:0] m_op1 = 0, m_op2 = 0;
  logic [31:0] m_res = 0, m_acc = 0;
  bit          m_carry = 0;

  always #2.5 clk = ~clk;

  mac_periph u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                 .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); addr = 16'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); addr = 16'(a); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  function automatic longint widen(input logic [15:0] v, input bit s);
    return s ? longint'($signed(v)) : longint'(v);
  endfunction

  function automatic logic [15:0] exp_ext();
    case (m_mode)
      2'd0: return 16'h0000;
      2'd2: return {15'd0, m_carry};
      default: return m_res[31] ? 16'hFFFF : 16'h0000;
    endcase
  endfunction

  task automatic model_op(input logic [15:0] b);
    longint p;
    logic [63:0] pw;
    logic [32:0] s33;
    p  = widen(m_op1, m_mode[0]) * widen(b, m_mode[0]);
    pw = 64'(p);
    m_op2 = b;
    if (m_mode[1]) begin
      s33 = {1'b0, m_acc} + {1'b0, pw[31:0]};
      m_acc = s33[31:0]; m_res = s33[31:0];
      m_carry = !m_mode[0] && s33[32];
    end else begin
      m_res = pw[31:0]; m_acc = 0; m_carry = 0;
    end
  endtask

  task automatic set_mode(input int m, input logic [15:0] a);
    wr(B + 2*m, a); m_mode = 2'(m); m_op1 = a;
  endtask

  task automatic run_op(input logic [15:0] b);
    wr(B + 'h8, b); model_op(b);
  endtask

  task automatic preload(input logic [15:0] v);
    wr(B + 'hA, v);
    m_res = m_mode[0] ? {{16{v[15]}}, v} : {16'h0, v};
    m_acc = m_res; m_carry = 0;
  endtask

  task automatic check_result(input string tag);
    logic [15:0] d;
    rd(B + 'hA, d); check({tag, " R8 low"}, d, m_res[15:0]);
    rd(B + 'hC, d); check({tag, " R8 high"}, d, m_res[31:16]);
    rd(B + 'hE, d); check({tag, " R6 ext"}, d, exp_ext());
  endtask

  logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5C3};

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    d = rdata; check("R10 rdata after reset", d, 16'h0);
    rst_n = 1'b1;
    rd(B + 'hA, d); check("R10 low", d, 16'h0);
    rd(B + 'hC, d); check("R10 high", d, 16'h0);
    rd(B + 'hE, d); check("R10 ext", d, 16'h0);
    rd(B, d);       check("R10 op1", d, 16'h0);
    rd(B + 'h8, d); check("R10 op2", d, 16'h0);

    // R1 R2 R3 R4 R5: sweep modes and operand pairs
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          set_mode(m, vals[i]);
          run_op(vals[j]);
          check_result($sformatf("R3R4R5 m%0d %h*%h", m, vals[i], vals[j]));
        end
      end
      rd(B + 2*m, d); check("R1 op1 readback", d, m_op1);
      rd(B + 'h6 - 2*m, d); check("R1 op1 alias readback", d, m_op1);
      rd(B + 'h8, d); check("R2 op2 readback", d, m_op2);
    end

    // R3: multiply clears accumulator so next accumulate starts at zero
    set_mode(2, 16'h0100); run_op(16'h0100);
    set_mode(0, 16'h0003); run_op(16'h0005);
    set_mode(2, 16'h0002); run_op(16'h0002);
    rd(B + 'hA, d); check("R3 acc restarted", d, 16'h0004);
    rd(B + 'hC, d); check("R3 acc restarted high", d, 16'h0000);
    check_result("R3 model");

    // R6: unsigned accumulate carry out
    set_mode(2, 16'hFFFF); preload(16'h0000);
    run_op(16'hFFFF); run_op(16'hFFFF);
    rd(B + 'hE, d); check("R6 umac carry", d, 16'h0001);
    run_op(16'h0000);
    rd(B + 'hE, d); check("R6 umac no carry", d, 16'h0000);
    // R6: ext follows current mode
    set_mode(1, 16'hFFFF); run_op(16'h0001);
    rd(B + 'hE, d); check("R6 smul negative", d, 16'hFFFF);
    set_mode(0, 16'h0001);
    rd(B + 'hE, d); check("R6 ext after switch to umul", d, 16'h0000);

    // R7: preload widening
    set_mode(2, 16'h0001); preload(16'h8001);
    rd(B + 'hC, d); check("R7 zero-extended preload", d, 16'h0000);
    run_op(16'h0001); check_result("R7 umac after preload");
    set_mode(3, 16'h0001); preload(16'h8001);
    rd(B + 'hC, d); check("R7 sign-extended preload", d, 16'hFFFF);
    rd(B + 'hE, d); check("R7 smac ext after preload", d, 16'hFFFF);
    run_op(16'h7FFF); check_result("R7 smac after preload");

    // R9: odd and out-of-window accesses
    wr(B + 'hB, 16'h1234); check_result("R9 odd write ignored");
    wr(B + 'h9, 16'h5555); rd(B + 'h8, d); check("R9 odd op2 write ignored", d, m_op2);
    wr(B + 'h10, 16'hBEEF); wr(B - 2, 16'hBEEF); check_result("R9 outside write ignored");
    rd(B, d); check("R9 op1 unchanged", d, m_op1);
    rd(B + 'hB, d); check("R9 odd read zero", d, 16'h0);
    rd(B + 'h10, d); check("R9 outside read zero", d, 16'h0);
    rd(B - 2, d); check("R9 below read zero", d, 16'h0);

    // R8: data holds while no read
    rd(B + 'hC, d);
    repeat (3) @(negedge clk);
    check("R8 hold", rdata, m_res[31:16]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule